// File: doc/BRIEF.md
# Program Fetch Memory Selector

This block steers every program-fetch address to either the on-chip code store or the off-chip code bus. The 64K program space splits at a 4K boundary. The low part is served on-chip when the external-access level is high. Everything goes off-chip when that level is low. The level is taken while reset is held and then kept until the next reset, so later movement on the pin has no effect. An off-chip fetch drives an active-low program-store strobe.

The block also keeps the code-protection lock bits. While any lock bit is set, a programmer's read-back of on-chip code returns all-ones instead of the stored byte. An erase command is the only way to clear the lock bits. In the cycle that the lock bits clear, the block also issues a one-cycle memory-clear request to the on-chip array and a one-cycle erase-done flag. Reset does not touch the lock bits. Off-chip fetches are never affected by the lock.

Top module: `prog_fetch_sel`

## Requirements
- R1: While `rst` is high at a clock edge, the following edge leaves `int_sel`=0, `ext_sel`=0, `psen_n`=1, `rd_vld`=0, `rd_out`=all ones, `mem_clear`=0 and `erase_done`=0.
- R2: With the held external-access level high, a fetch is routed on-chip one cycle later.
  - A fetch below 0x1000 gives `int_sel`=1 and `ext_sel`=0.
  - A fetch at or above 0x1000 gives `ext_sel`=1 and `int_sel`=0.
- R3: With the held external-access level low, every fetch gives `ext_sel`=1 one cycle later, including addresses 0x0000 to 0x0FFF.
- R4: `psen_n` is 0 exactly in the cycles where `ext_sel` is 1. A cycle with no fetch strobe gives `int_sel`=0 and `ext_sel`=0 one cycle later.
- R5: `lock_wr` ORs `lock_val` into the lock bits. From the next cycle onward, a read request while any lock bit is set gives `rd_vld`=1 and `rd_out`=all ones one cycle later.
- R6: While no lock bit is set, a read request gives `rd_vld`=1 and `rd_out` equal to the `rd_data` sampled with the request, one cycle later. A cycle with no request gives `rd_vld`=0 and `rd_out`=all ones.
- R7: One cycle after `erase_req`, `mem_clear` and `erase_done` are both 1 for one cycle and the lock bits are zero. Erase wins over a `lock_wr` in the same cycle.
- R8: Reset does not clear the lock bits.
- R9: Changes on `ea_pin` while `rst` is low do not change routing.
- R10: A set lock never blocks off-chip fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; `ea_pin` is sampled while it is high |
| fetch_vld | input | 1 | Fetch strobe |
| fetch_addr | input | 16 | Fetch address |
| ea_pin | input | 1 | External-access level |
| lock_wr | input | 1 | Program lock bits |
| lock_val | input | 2 | Bits to set when `lock_wr` is high |
| erase_req | input | 1 | Erase command |
| rd_req | input | 1 | Programmer read-back request |
| rd_data | input | 8 | Byte from the on-chip array for the read-back |
| int_sel | output | 1 | On-chip code memory selected |
| ext_sel | output | 1 | Off-chip code memory selected |
| psen_n | output | 1 | Active-low program-store strobe |
| rd_vld | output | 1 | Read-back result valid |
| rd_out | output | 8 | Gated read-back byte |
| mem_clear | output | 1 | Clear request to the on-chip array |
| erase_done | output | 1 | Erase complete flag |

## Verification
The bench uses the default parameters: 16-bit addresses, a 4096-byte on-chip region, two lock bits and 8-bit data. With these values the edge addresses 0x0FFF, 0x1000, 0x0000 and 0xFFFF can be driven directly. A swept address walk crosses the boundary many times.

Three resets are applied with different external-access levels, and lock bits are set before one of them. This exposes both the hold of the sampled level and the survival of the lock across reset. A behavioural model predicts every output on every cycle. That includes an erase issued together with a lock write.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    ROUTE_IDLE = 2'd0,
    ROUTE_INT  = 2'd1,
    ROUTE_EXT  = 2'd2
  } route_e;
endpackage

// File: rtl/pfs_ea_latch.sv
module pfs_ea_latch (
  input  logic clk,
  input  logic rst,
  input  logic ea_pin,
  output logic ea_hold
);
  // Follows the pin while reset is held; frozen once reset drops.
  always_ff @(posedge clk) begin
    if (rst) ea_hold <= ea_pin;
  end
endmodule

// File: rtl/pfs_route.sv
module pfs_route
  import pfs_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned ONCHIP_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_vld,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              ea_hold,
  output logic              int_sel,
  output logic              ext_sel,
  output logic              psen_n
);
  localparam int unsigned LIMIT = ONCHIP_BYTES;

  route_e route_d;

  always_comb begin
    route_d = ROUTE_IDLE;
    if (fetch_vld) begin
      if (ea_hold && (32'(fetch_addr) < LIMIT)) route_d = ROUTE_INT;
      else                                      route_d = ROUTE_EXT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_sel <= 1'b0;
      ext_sel <= 1'b0;
      psen_n  <= 1'b1;
    end else begin
      int_sel <= (route_d == ROUTE_INT);
      ext_sel <= (route_d == ROUTE_EXT);
      psen_n  <= (route_d != ROUTE_EXT);
    end
  end

  a_r2_low_on_chip: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && ea_hold && (32'(fetch_addr) < LIMIT)) |=> (int_sel && !ext_sel));
  a_r3_ea_low_off_chip: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && !ea_hold) |=> (ext_sel && !psen_n));
  a_r4_idle_no_select: assert property (@(posedge clk) disable iff (rst)
    !fetch_vld |=> (!int_sel && !ext_sel && psen_n));
  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(int_sel && ext_sel));
endmodule

// File: rtl/pfs_lock.sv
module pfs_lock #(
  parameter int unsigned LOCK_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lock_wr,
  input  logic [LOCK_BITS-1:0] lock_val,
  input  logic                 erase_req,
  output logic                 locked,
  output logic                 mem_clear,
  output logic                 erase_done
);
  // Non-volatile in spirit: reset leaves these untouched.
  logic [LOCK_BITS-1:0] lock_q = '0;

  always_ff @(posedge clk) begin
    if (!rst) begin
      if (erase_req)    lock_q <= '0;
      else if (lock_wr) lock_q <= lock_q | lock_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_clear  <= 1'b0;
      erase_done <= 1'b0;
    end else begin
      mem_clear  <= erase_req;
      erase_done <= erase_req;
    end
  end

  assign locked = |lock_q;

  a_r7_erase_clears: assert property (@(posedge clk) disable iff (rst)
    erase_req |=> (lock_q == '0 && mem_clear && erase_done));
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    (locked && !erase_req) |=> locked);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (!erase_req) |=> !mem_clear);
endmodule

// File: rtl/prog_fetch_sel.sv
module prog_fetch_sel #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned ONCHIP_BYTES = 4096,
  parameter int unsigned LOCK_BITS    = 2,
  parameter int unsigned DATA_W       = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fetch_vld,
  input  logic [ADDR_W-1:0]    fetch_addr,
  input  logic                 ea_pin,
  input  logic                 lock_wr,
  input  logic [LOCK_BITS-1:0] lock_val,
  input  logic                 erase_req,
  input  logic                 rd_req,
  input  logic [DATA_W-1:0]    rd_data,
  output logic                 int_sel,
  output logic                 ext_sel,
  output logic                 psen_n,
  output logic                 rd_vld,
  output logic [DATA_W-1:0]    rd_out,
  output logic                 mem_clear,
  output logic                 erase_done
);
  localparam logic [DATA_W-1:0] REFUSED = '1;

  logic ea_hold;
  logic locked;

  pfs_ea_latch u_ea (
    .clk(clk), .rst(rst), .ea_pin(ea_pin), .ea_hold(ea_hold)
  );

  pfs_route #(.ADDR_W(ADDR_W), .ONCHIP_BYTES(ONCHIP_BYTES)) u_route (
    .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .ea_hold(ea_hold), .int_sel(int_sel), .ext_sel(ext_sel), .psen_n(psen_n)
  );

  pfs_lock #(.LOCK_BITS(LOCK_BITS)) u_lock (
    .clk(clk), .rst(rst), .lock_wr(lock_wr), .lock_val(lock_val),
    .erase_req(erase_req), .locked(locked), .mem_clear(mem_clear),
    .erase_done(erase_done)
  );

  // Read-back gate
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
      rd_out <= REFUSED;
    end else begin
      rd_vld <= rd_req;
      rd_out <= (rd_req && !locked) ? rd_data : REFUSED;
    end
  end

  a_r5_refused_ones: assert property (@(posedge clk) disable iff (rst)
    (rd_req && locked) |=> (rd_vld && rd_out == REFUSED));
  a_r6_open_passes: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !locked) |=> (rd_vld && rd_out == $past(rd_data)));
  a_r10_ext_not_blocked: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && locked && 32'(fetch_addr) >= ONCHIP_BYTES) |=> ext_sel);
endmodule

// File: tb/sim_prog_fetch_sel.sv
module sim_prog_fetch_sel;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_vld = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic ea_pin = 1'b1;
  logic lock_wr = 1'b0;
  logic [1:0] lock_val = '0;
  logic erase_req = 1'b0;
  logic rd_req = 1'b0;
  logic [7:0] rd_data = '0;
  logic int_sel, ext_sel, psen_n, rd_vld, mem_clear, erase_done;
  logic [7:0] rd_out;

  int errors = 0;
  int checks = 0;

  prog_fetch_sel u0 (
    .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
    .ea_pin(ea_pin), .lock_wr(lock_wr), .lock_val(lock_val),
    .erase_req(erase_req), .rd_req(rd_req), .rd_data(rd_data),
    .int_sel(int_sel), .ext_sel(ext_sel), .psen_n(psen_n), .rd_vld(rd_vld),
    .rd_out(rd_out), .mem_clear(mem_clear), .erase_done(erase_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  bit ea_m, started;
  int lock_m = 0;
  bit e_int, e_ext, e_psen, e_vld, e_clr, e_done, e_rst;
  int e_out;

  always @(posedge clk) begin
    started <= 1'b1;
    e_rst   <= rst;
    if (rst) begin
      ea_m <= ea_pin;
      e_int <= 0; e_ext <= 0; e_psen <= 1; e_vld <= 0;
      e_out <= 255; e_clr <= 0; e_done <= 0;
    end else begin
      bit on_chip;
      on_chip = fetch_vld && ea_m && (fetch_addr < 16'h1000);
      e_int  <= on_chip;
      e_ext  <= fetch_vld && !on_chip;
      e_psen <= !(fetch_vld && !on_chip);
      e_vld  <= rd_req;
      e_out  <= (rd_req && lock_m == 0) ? int'(rd_data) : 255;
      e_clr  <= erase_req;
      e_done <= erase_req;
      if (erase_req)    lock_m <= 0;
      else if (lock_wr) lock_m <= lock_m | int'(lock_val);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      string pre;
      pre = e_rst ? "R1 " : "";
      chk({pre, "R2/R3/R9 int_sel"}, int'(int_sel), int'(e_int));
      chk({pre, "R2/R3/R10 ext_sel"}, int'(ext_sel), int'(e_ext));
      chk({pre, "R4 psen_n"}, int'(psen_n), int'(e_psen));
      chk({pre, "R5/R6 rd_vld"}, int'(rd_vld), int'(e_vld));
      chk({pre, "R5/R6/R8 rd_out"}, int'(rd_out), e_out);
      chk({pre, "R7 mem_clear"}, int'(mem_clear), int'(e_clr));
      chk({pre, "R7 erase_done"}, int'(erase_done), int'(e_done));
    end
  end

  task automatic idle();
    fetch_vld = 0; lock_wr = 0; erase_req = 0; rd_req = 0;
  endtask

  task automatic fetch(input logic [15:0] a);
    @(negedge clk); idle(); fetch_vld = 1; fetch_addr = a;
  endtask

  task automatic read(input logic [7:0] d);
    @(negedge clk); idle(); rd_req = 1; rd_data = d;
  endtask

  task automatic do_reset(input logic ea);
    @(negedge clk); idle(); rst = 1; ea_pin = ~ea;
    @(negedge clk); ea_pin = ea;
    @(negedge clk); rst = 0; ea_pin = ~ea;   // R9: pin moves after release
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] walk;
    do_reset(1'b1);
    // R2 boundary and R4 idle
    fetch(16'h0000); fetch(16'h0FFF); fetch(16'h1000); fetch(16'hFFFF);
    @(negedge clk); idle();
    walk = 16'h0123;
    for (int i = 0; i < 40; i++) begin
      fetch(walk);
      walk = walk * 16'd5 + 16'h0F3B;
    end
    // R6 open read-back
    read(8'h5A); read(8'h00);
    // R5 lock then refused reads; R10 off-chip still served
    @(negedge clk); idle(); lock_wr = 1; lock_val = 2'b10;
    read(8'h5A); read(8'hC3);
    fetch(16'h1000); fetch(16'h0010);
    @(negedge clk); idle(); lock_wr = 1; lock_val = 2'b01;
    read(8'h77);
    // R8/R3 reset with pin low keeps lock
    do_reset(1'b0);
    read(8'h11);
    fetch(16'h0000); fetch(16'h0FFF); fetch(16'h2000);
    // R7 erase together with lock write
    @(negedge clk); idle(); erase_req = 1; lock_wr = 1; lock_val = 2'b11;
    read(8'h3C);
    @(negedge clk); idle(); erase_req = 1;
    read(8'hE1);
    // R2 again after reset with pin high
    do_reset(1'b1);
    fetch(16'h0FFF); fetch(16'h1001);
    read(8'h42);
    @(negedge clk); idle();
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule